// File: doc/BRIEF.md
# Dual-Channel Status Byte-Access Buffer

This block holds the channel status words of a two-subframe audio transmitter. Each of its words is 16 bits wide. The high byte belongs to subframe A and the low byte to subframe B. A host reaches the store one byte at a time, through a write stream and a read stream. Both streams share an address pointer, which the host loads directly and which can advance by itself, so that a whole block can be moved in one burst. The transmit side has a separate read port. It is independent of the host side and returns a full word one cycle after the address is presented.

A mode input selects how bytes map onto words. In mirrored mode, each written byte fills both halves of the addressed word, and a read returns the half named by a select input. In paired mode, a word takes two transfers in a fixed order, subframe A and then subframe B. The pointer advances only after the B transfer.

Back-pressure rules: a write byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only during an address-load cycle. A read byte is taken on an edge where `rd_valid` and `rd_ready` are both high. `rd_valid` is low during an address load and in any cycle where `wr_valid` is high, so writes take precedence. `rd_data` is valid whenever `rd_valid` is high, and it may change after any accepted transfer. Reads and writes share one pointer and one byte phase.

Top module: `chs_byte_buffer`

## Requirements
- R1: After reset, every word is zero and the pointer is at word 0 with the phase expecting the A byte. The A byte is bits 15:8 of a word and the B byte is bits 7:0.
- R2: In mirrored mode (`cfg_pair_mode`=0), an accepted write byte is stored into both bits 15:8 and bits 7:0 of the addressed word.
- R3: In mirrored mode, a read returns bits 15:8 when `cfg_rd_sel_b`=0 and bits 7:0 when `cfg_rd_sel_b`=1.
- R4: In paired mode (`cfg_pair_mode`=1), two successive reads of a word return bits 15:8 first and bits 7:0 second.
- R5: In paired mode, the first accepted write byte is the A byte and the second is the B byte. The word in storage does not change until the B byte is accepted, and then both bytes are written at once.
- R6: With `cfg_auto_inc`=1, the pointer advances after every accepted byte in mirrored mode, and only after the B byte in paired mode. With `cfg_auto_inc`=0, the pointer holds, although the paired phase still alternates.
- R7: Advancing from word 23 takes the pointer to word 0.
- R8: When `addr_load` is high, the pointer is set to `addr_value` (or to 0 if `addr_value` is 24 or more) and the phase returns to A. In that cycle no byte is accepted.
- R9: `tx_word` shows the word at `tx_addr` as it stood at the previous clock edge, with a latency of one cycle. An address of 24 or more reads as zero.
- R10: `rd_valid` is low whenever `wr_valid` is high. A byte moves only on an edge where both valid and ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pair_mode | input | 1 | 1 selects paired A-then-B access, 0 selects mirrored access |
| cfg_rd_sel_b | input | 1 | Mirrored-mode read half: 0 selects A, 1 selects B |
| cfg_auto_inc | input | 1 | Enables pointer advance after each completed word or byte |
| addr_load | input | 1 | Loads the pointer and clears the phase |
| addr_value | input | 5 | Word address to load |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte on offer |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| tx_addr | input | 5 | Transmit-side word address |
| tx_word | output | 16 | Transmit-side word, registered |

## Verification
The hardest state to reach from the ports is the pointer at word 23 in paired mode with one byte pending. At that point the next B byte must commit the word and also wrap the pointer to 0. A stray address load in the middle of a pair must discard the pending A byte. To reach these states, the stimulus loads 23 directly and writes a pair. It also loads an address, sends only an A byte, and reloads. It then compares the transmit port against a reference array, both before and after the B byte. Pointer hold with auto-increment off is brought out by reading the same word repeatedly, and the alternating phase shows up as an A, B, A, B pattern.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int unsigned CHS_WORDS_DEF  = 24;
  localparam int unsigned CHS_BYTE_W_DEF = 8;

  // Byte phase within a word in paired mode.
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/chs_addr_seq.sv
// Word pointer and paired-mode byte phase.
module chs_addr_seq
  import chs_pkg::*;
#(
  parameter int unsigned WORDS = CHS_WORDS_DEF,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          auto_inc,
  input  logic          pair_mode,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output phase_e        phase
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
  localparam logic [AW-1:0] LIMIT = AW'(WORDS - 1);

  logic          word_done;
  logic [AW-1:0] addr_next;
  logic [AW-1:0] load_clamped;

  // A word completes on every byte in mirrored mode, on the B byte in paired mode.
  assign word_done    = !pair_mode || (phase == PH_B);
  assign addr_next    = (cur_addr == LAST) ? '0 : cur_addr + AW'(1);
  assign load_clamped = (load_addr <= LIMIT) ? load_addr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      phase    <= PH_A;
    end else if (load) begin
      cur_addr <= load_clamped;
      phase    <= PH_A;
    end else if (step) begin
      if (word_done && auto_inc) begin
        cur_addr <= addr_next;
      end
      phase <= (pair_mode && phase == PH_A) ? PH_B : PH_A;
    end else if (!pair_mode) begin
      phase <= PH_A;
    end
  end
endmodule

// File: rtl/chs_store.sv
// Register store: one host write port, a combinational host read port,
// a registered transmit read port.
module chs_store
  import chs_pkg::*;
#(
  parameter int unsigned WORDS  = CHS_WORDS_DEF,
  parameter int unsigned BYTE_W = CHS_BYTE_W_DEF,
  localparam int unsigned AW = $clog2(WORDS),
  localparam int unsigned WW = 2 * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] host_addr,
  output logic [WW-1:0] host_word,
  input  logic [AW-1:0] tx_addr,
  output logic [WW-1:0] tx_word
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic [WW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic          hit;
    logic [WW-1:0] q;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wdata;
      end
    end
    assign words[g] = q;
  end

  always_comb begin
    host_word = '0;
    if (host_addr <= LAST) begin
      host_word = words[host_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word <= '0;
    end else if (tx_addr <= LAST) begin
      tx_word <= words[tx_addr];
    end else begin
      tx_word <= '0;
    end
  end
endmodule

// File: rtl/chs_host_port.sv
// Byte streams to and from the host: handshake, A-byte staging, byte selection.
module chs_host_port
  import chs_pkg::*;
#(
  parameter int unsigned BYTE_W = CHS_BYTE_W_DEF,
  localparam int unsigned WW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_mode,
  input  logic              rd_sel_b,
  input  logic              load,
  input  phase_e            phase,
  input  logic [WW-1:0]     host_word,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              step,
  output logic              we,
  output logic [WW-1:0]     wdata
);
  logic              wr_fire;
  logic              rd_fire;
  logic [BYTE_W-1:0] stage_a;
  logic [BYTE_W-1:0] half_a;
  logic [BYTE_W-1:0] half_b;

  assign wr_ready = !load;
  assign rd_valid = !load && !wr_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign step     = wr_fire || rd_fire;

  // Paired mode: hold the A byte until the B byte arrives.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a <= '0;
    end else if (wr_fire && pair_mode && phase == PH_A) begin
      stage_a <= wr_data;
    end
  end

  assign we    = wr_fire && (!pair_mode || phase == PH_B);
  assign wdata = pair_mode ? {stage_a, wr_data} : {wr_data, wr_data};

  assign half_a = host_word[WW-1:BYTE_W];
  assign half_b = host_word[BYTE_W-1:0];

  always_comb begin
    if (pair_mode) begin
      rd_data = (phase == PH_A) ? half_a : half_b;
    end else begin
      rd_data = rd_sel_b ? half_b : half_a;
    end
  end
endmodule

// File: rtl/chs_byte_buffer.sv
module chs_byte_buffer
  import chs_pkg::*;
#(
  parameter int unsigned WORDS  = CHS_WORDS_DEF,
  parameter int unsigned BYTE_W = CHS_BYTE_W_DEF,
  localparam int unsigned AW = $clog2(WORDS),
  localparam int unsigned WW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pair_mode,
  input  logic              cfg_rd_sel_b,
  input  logic              cfg_auto_inc,
  input  logic              addr_load,
  input  logic [AW-1:0]     addr_value,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [AW-1:0]     tx_addr,
  output logic [WW-1:0]     tx_word
);
  logic [AW-1:0] cur_addr;
  phase_e        cur_phase;
  logic          step;
  logic          we;
  logic [WW-1:0] wdata;
  logic [WW-1:0] host_word;

  chs_addr_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_load),
    .load_addr (addr_value),
    .auto_inc  (cfg_auto_inc),
    .pair_mode (cfg_pair_mode),
    .step      (step),
    .cur_addr  (cur_addr),
    .phase     (cur_phase)
  );

  chs_store #(.WORDS(WORDS), .BYTE_W(BYTE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .waddr     (cur_addr),
    .wdata     (wdata),
    .host_addr (cur_addr),
    .host_word (host_word),
    .tx_addr   (tx_addr),
    .tx_word   (tx_word)
  );

  chs_host_port #(.BYTE_W(BYTE_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_mode (cfg_pair_mode),
    .rd_sel_b  (cfg_rd_sel_b),
    .load      (addr_load),
    .phase     (cur_phase),
    .host_word (host_word),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .step      (step),
    .we        (we),
    .wdata     (wdata)
  );
endmodule

// File: rtl/chs_checker.sv
module chs_checker
  import chs_pkg::*;
#(
  parameter int unsigned WORDS = CHS_WORDS_DEF,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_pair_mode,
  input logic          cfg_auto_inc,
  input logic          addr_load,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] cur_addr,
  input phase_e        phase
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic xfer;
  logic word_end;
  assign xfer     = (wr_valid && wr_ready) || (rd_valid && rd_ready);
  assign word_end = !cfg_pair_mode || (phase == PH_B);

  assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_addr <= LAST);

  assert_load_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> (!wr_ready && !rd_valid));

  assert_load_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (phase == PH_A));

  assert_rd_yield_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_valid);

  assert_single_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pair_mode && !addr_load) |=> (phase == PH_A));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && !xfer) |=> $stable(cur_addr));

  assert_no_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && xfer && (!cfg_auto_inc || !word_end)) |=> $stable(cur_addr));

  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && xfer && cfg_auto_inc && word_end && cur_addr != LAST)
      |=> (cur_addr == AW'($past(cur_addr) + AW'(1))));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && xfer && cfg_auto_inc && word_end && cur_addr == LAST)
      |=> (cur_addr == '0));
endmodule

bind chs_byte_buffer chs_checker #(.WORDS(WORDS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_pair_mode (cfg_pair_mode),
  .cfg_auto_inc  (cfg_auto_inc),
  .addr_load     (addr_load),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .cur_addr      (cur_addr),
  .phase         (cur_phase)
);

// File: tb/sim_chs_byte_buffer.sv
module sim_chs_byte_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pair_mode = 1'b0;
  logic        cfg_rd_sel_b = 1'b0;
  logic        cfg_auto_inc = 1'b1;
  logic        addr_load = 1'b0;
  logic [4:0]  addr_value = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic [4:0]  tx_addr = '0;
  logic [15:0] tx_word;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chs_byte_buffer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pair_mode(cfg_pair_mode),
    .cfg_rd_sel_b(cfg_rd_sel_b), .cfg_auto_inc(cfg_auto_inc),
    .addr_load(addr_load), .addr_value(addr_value),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tx_addr(tx_addr), .tx_word(tx_word)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model, built from the requirements.
  logic [15:0] ref_mem [NW];
  int          ref_addr = 0;
  bit          ref_ph_b = 1'b0;
  logic [7:0]  ref_stage = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void ref_step(bit word_end);
    if (word_end && cfg_auto_inc) ref_addr = (ref_addr == NW - 1) ? 0 : ref_addr + 1;
    ref_ph_b = cfg_pair_mode ? !ref_ph_b : 1'b0;
  endfunction

  task automatic do_load(int a);
    addr_load = 1'b1; addr_value = 5'(a);
    @(posedge clk); #1;
    addr_load = 1'b0;
    ref_addr = (a < NW) ? a : 0;
    ref_ph_b = 1'b0;
  endtask

  task automatic do_write(logic [7:0] b);
    bit word_end;
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    check("R10 rd_valid during write", {15'd0, rd_valid}, 16'd0);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    word_end = !cfg_pair_mode || ref_ph_b;
    if (!cfg_pair_mode) ref_mem[ref_addr] = {b, b};
    else if (!ref_ph_b) ref_stage = b;
    else ref_mem[ref_addr] = {ref_stage, b};
    ref_step(word_end);
  endtask

  task automatic do_read(string tag);
    logic [15:0] w;
    w = ref_mem[ref_addr];
    if (cfg_pair_mode) exp_q.push_back(ref_ph_b ? w[7:0] : w[15:8]);
    else exp_q.push_back(cfg_rd_sel_b ? w[7:0] : w[15:8]);
    tag_q.push_back(tag);
    rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_ready = 1'b0;
    ref_step(!cfg_pair_mode || ref_ph_b);
  endtask

  task automatic check_tx(int a, string tag);
    tx_addr = 5'(a);
    @(posedge clk); #1;
    check(tag, tx_word, (a < NW) ? ref_mem[a] : 16'd0);
  endtask

  // Monitor: compares each accepted read byte against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected read", {8'd0, rd_data}, 16'hxxxx);
      end else begin
        check(tag_q.pop_front(), {8'd0, rd_data}, {8'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: reset state
    check("R1 wr_ready after reset", {15'd0, wr_ready}, 16'd1);
    check_tx(0, "R1 word0 zero");
    check_tx(23, "R1 word23 zero");
    do_read("R1 first read zero");

    // R2 / R7: mirrored burst over all words, wrap back to 0
    do_load(0);
    for (int i = 0; i < NW; i++) do_write(8'(i * 7 + 3));
    check_tx(0, "R2 mirror word0");
    check_tx(13, "R2 mirror word13");
    check_tx(23, "R2 mirror word23");
    do_read("R7 wrap after 24 bytes");

    // R5: paired writes, word unchanged until B byte
    cfg_pair_mode = 1'b1;
    do_load(5);
    do_write(8'h11);
    check_tx(5, "R5 word held after A byte");
    do_write(8'h22);
    check_tx(5, "R5 word after B byte");
    do_write(8'h33); do_write(8'h44);
    do_write(8'h55); do_write(8'h66);
    check_tx(7, "R5 word7 pair");
    // R4: paired reads A then B
    do_load(5);
    for (int i = 0; i < 6; i++) do_read("R4 paired read order");

    // R3: mirrored reads select half
    cfg_pair_mode = 1'b0;
    do_load(5);
    cfg_rd_sel_b = 1'b1;
    cfg_auto_inc = 1'b0;
    do_read("R3 select B half");
    cfg_rd_sel_b = 1'b0;
    do_read("R3 select A half");

    // R6: auto-increment off holds pointer
    do_load(10);
    do_write(8'hA1); do_write(8'hA2); do_write(8'hA3);
    check_tx(10, "R6 hold pointer mirrored");
    check_tx(11, "R6 neighbour untouched");
    cfg_pair_mode = 1'b1;
    do_load(6);
    for (int i = 0; i < 4; i++) do_read("R6 paired hold alternates");
    cfg_auto_inc = 1'b1;

    // R8: reload mid-pair discards the pending A byte
    do_load(8);
    do_write(8'h5A);
    do_load(8);
    do_write(8'h66); do_write(8'h77);
    check_tx(8, "R8 reload restarts pair");
    // R8: out-of-range load maps to 0
    do_load(30);
    do_read("R8 out-of-range load to word0 A");
    do_read("R8 out-of-range load to word0 B");

    // R7: paired wrap from 23 to 0
    do_load(23);
    do_write(8'hC1); do_write(8'hC2);
    do_write(8'hD1); do_write(8'hD2);
    check_tx(23, "R7 word23 paired");
    check_tx(0, "R7 wrapped to word0");

    // R8 / R10: write offered during load is not taken
    cfg_pair_mode = 1'b0;
    addr_load = 1'b1; addr_value = 5'd12; wr_valid = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    check("R8 wr_ready low on load", {15'd0, wr_ready}, 16'd0);
    check("R8 rd_valid low on load", {15'd0, rd_valid}, 16'd0);
    @(posedge clk); #1;
    addr_load = 1'b0; wr_valid = 1'b0;
    ref_addr = 12; ref_ph_b = 1'b0;
    check_tx(12, "R8 no write during load");

    // R9: one-cycle latency and out-of-range transmit address
    tx_addr = 5'd5;
    @(posedge clk); #1;
    tx_addr = 5'd23;
    @(negedge clk);
    check("R9 previous word before edge", tx_word, ref_mem[5]);
    @(posedge clk); #1;
    check("R9 new word after edge", tx_word, ref_mem[23]);
    check_tx(31, "R9 out-of-range tx reads zero");

    repeat (2) @(posedge clk);
    check("R10 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finished = 1'b1;
    finish_run();
  end
endmodule